// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a running seconds, minutes, hours and day value, supplied from an external timekeeping counter, and raises an alarm when that time agrees with four host-programmed alarm registers. Each alarm register holds a 7-bit BCD value in bits 6:0 and a mask bit in bit 7. A set mask removes its field from the comparison. Setting the masks from the day field downward makes the alarm repeat weekly, daily, hourly, every minute or every second.

The comparison is made only on the cycle in which the external counter pulses `tick`, which marks a seconds update. A match on that cycle sets a sticky alarm flag. The flag stays set until the host pulses `irq_clr`. The active-low `irq_n` output is low only while both the flag and the interrupt-enable bit are set. The flag itself latches whatever the enable bit holds.

The host reaches the alarm registers, the enable bit and the flag through a plain single-cycle write port and a combinational read port. There is no data stream, so every pin is a plain control or status pin with no handshake.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset the four alarm registers and the enable bit read 0, `irq_flag` is 0 and `irq_n` is 1.
- R2: With all four mask bits (bit 7) clear, a `tick` sets the flag only when seconds, minutes, hours and day all equal bits 6:0 of their alarm registers. A difference in any one field prevents it.
- R3: With only the day mask set, a `tick` sets the flag when hours, minutes and seconds match, whatever the day value.
- R4: With the day and hour masks set, a `tick` sets the flag when minutes and seconds match. A minutes difference prevents it.
- R5: With the day, hour and minute masks set, a `tick` sets the flag when seconds match. A seconds difference prevents it.
- R6: With all four masks set, every `tick` sets the flag, whatever bits 6:0 of the alarm registers hold.
- R7: The flag is set only on the rising clock edge that samples `tick` high. Host writes that make the alarm registers equal the present time do not set it.
- R8: Once set, the flag stays set across ticks that do not match until `irq_clr` is sampled high. When `irq_clr` and a matching `tick` fall in the same cycle, the flag ends up set.
- R9: `irq_n` is 0 exactly when the flag is 1 and the enable bit is 1. With the enable bit at 0 the flag still latches and `irq_n` stays 1.
- R10: Host address map: 07h seconds alarm, 08h minutes alarm, 09h hours alarm, 0Ah day alarm (all 8 bits read and write). 0Bh bit 0 is the interrupt enable. 0Ch bit 0 is the read-only flag. Every other bit and address reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse: time inputs hold a new seconds value |
| sec_in | input | 7 | Current seconds, BCD |
| min_in | input | 7 | Current minutes, BCD |
| hour_in | input | 7 | Current hours register value, bits 6:0 |
| day_in | input | 7 | Current day, bits 6:0 |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 7 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 7 | Host read address |
| host_rdata | output | 8 | Host read data, combinational from `host_raddr` |
| irq_clr | input | 1 | Pulse that clears the alarm flag |
| irq_flag | output | 1 | Latched alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The comparator is driven with time vectors that differ from the alarm in exactly one field at a time, under each nested mask setting. This shows which field a given mask level actually consults, and a near miss in a field that is still unmasked shows that field is still compared. Writes that make the alarm equal the present time without a `tick`, and a clear that lands on the same cycle as a hit, separate the update-only set rule from the priority of the flag. Toggling the enable bit while the flag is held separates the latched flag from the gated interrupt pin.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int REG_W      = 8;
  localparam int FIELD_W    = 7;
  localparam int NUM_FIELDS = 4;
  localparam int ADDR_W     = 7;
  localparam int MASK_BIT   = REG_W - 1;

  // Field order is also the address order from the alarm base upward.
  typedef enum int {
    FLD_SEC  = 0,
    FLD_MIN  = 1,
    FLD_HOUR = 2,
    FLD_DAY  = 3
  } field_e;

  localparam logic [ADDR_W-1:0] ADDR_ALM_BASE = 7'h07;
  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 7'h0B;
  localparam logic [ADDR_W-1:0] ADDR_STAT     = 7'h0C;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [REG_W-1:0]                    wr_data,
  input  logic [ADDR_W-1:0]                   rd_addr,
  input  logic                                flag_i,
  output logic [NUM_FIELDS-1:0][REG_W-1:0]    alarm_o,
  output logic                                aie_o,
  output logic [REG_W-1:0]                    rd_data
);
  logic [REG_W-1:0] alm_q [NUM_FIELDS];
  logic             aie_q;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_alm
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_ALM_BASE + ADDR_W'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        alm_q[i] <= '0;
      else if (wr_en && (wr_addr == MY_ADDR))
        alm_q[i] <= wr_data;
    end
    assign alarm_o[i] = alm_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      aie_q <= 1'b0;
    else if (wr_en && (wr_addr == ADDR_CTRL))
      aie_q <= wr_data[0];
  end
  assign aie_o = aie_q;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rd_addr == ADDR_ALM_BASE + ADDR_W'(i))
        rd_data = alm_q[i];
    end
    if (rd_addr == ADDR_CTRL) rd_data = {{(REG_W-1){1'b0}}, aie_q};
    if (rd_addr == ADDR_STAT) rd_data = {{(REG_W-1){1'b0}}, flag_i};
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import tod_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][REG_W-1:0]   alarm_i,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] time_i,
  output logic [NUM_FIELDS-1:0]              mask_o,
  output logic                               hit_o
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    assign mask_o[i] = alarm_i[i][MASK_BIT];
    assign fld_ok[i] = mask_o[i] | (alarm_i[i][FIELD_W-1:0] == time_i[i]);
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic aie_i,
  output logic flag_o,
  output logic irq_n_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else
      flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o  = flag_q;
  assign irq_n_o = ~(flag_q & aie_i);

  a_r8_sticky_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) && !$past(clr_i)) |-> flag_q);

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [6:0]        sec_in,
  input  logic [6:0]        min_in,
  input  logic [6:0]        hour_in,
  input  logic [6:0]        day_in,
  input  logic              host_wr,
  input  logic [6:0]        host_waddr,
  input  logic [7:0]        host_wdata,
  input  logic [6:0]        host_raddr,
  output logic [7:0]        host_rdata,
  input  logic              irq_clr,
  output logic              irq_flag,
  output logic              irq_n
);
  logic [NUM_FIELDS-1:0][REG_W-1:0]   alarm;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now;
  logic [NUM_FIELDS-1:0]              mask;
  logic                               aie;
  logic                               hit;

  assign now[FLD_SEC]  = sec_in;
  assign now[FLD_MIN]  = min_in;
  assign now[FLD_HOUR] = hour_in;
  assign now[FLD_DAY]  = day_in;

  alarm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr),
    .wr_addr (host_waddr),
    .wr_data (host_wdata),
    .rd_addr (host_raddr),
    .flag_i  (irq_flag),
    .alarm_o (alarm),
    .aie_o   (aie),
    .rd_data (host_rdata)
  );

  alarm_cmp u_cmp (
    .alarm_i (alarm),
    .time_i  (now),
    .mask_o  (mask),
    .hit_o   (hit)
  );

  alarm_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (tick & hit),
    .clr_i   (irq_clr),
    .aie_i   (aie),
    .flag_o  (irq_flag),
    .irq_n_o (irq_n)
  );

  a_r7_rise_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(tick));

  a_r6_all_masked_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&mask)) |=> irq_flag);

  a_r9_disabled_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
    !aie |-> irq_n);
endmodule

// File: tb/sim_tod_alarm_match.sv
module sim_tod_alarm_match;
  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic [6:0] sec_in = 0, min_in = 0, hour_in = 0, day_in = 0;
  logic host_wr = 0;
  logic [6:0] host_waddr = 0, host_raddr = 0;
  logic [7:0] host_wdata = 0;
  logic irq_clr = 0;
  logic [7:0] host_rdata;
  logic irq_flag, irq_n;

  always #10 clk = ~clk;

  tod_alarm_match u0 (.*);

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       fl;
    logic       irqn;
  } exp_t;
  exp_t q[$];

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  // bench-side model of the register state
  logic [7:0] m_alm [4];
  logic       m_aie  = 0;
  logic       m_flag = 0;

  function automatic logic [7:0] m_read(input logic [6:0] a);
    if (a >= 7'h07 && a <= 7'h0A) return m_alm[a - 7'h07];
    if (a == 7'h0B) return {7'b0, m_aie};
    if (a == 7'h0C) return {7'b0, m_flag};
    return 8'h00;
  endfunction

  function automatic bit m_match(input logic [6:0] s, m, h, d);
    logic [6:0] t [4];
    bit ok = 1;
    t[0] = s; t[1] = m; t[2] = h; t[3] = d;
    for (int i = 0; i < 4; i++)
      if (!m_alm[i][7] && (m_alm[i][6:0] != t[i])) ok = 0;
    return ok;
  endfunction

  task automatic step(input string tag, input bit tk, input logic [6:0] s, m, h, d,
                      input bit clr, input bit we, input logic [6:0] wa,
                      input logic [7:0] wd, input logic [6:0] ra);
    exp_t e;
    bit hit;
    @(posedge clk); #2;
    tick = tk; sec_in = s; min_in = m; hour_in = h; day_in = d;
    irq_clr = clr; host_wr = we; host_waddr = wa; host_wdata = wd; host_raddr = ra;
    hit = tk && m_match(s, m, h, d);
    m_flag = hit | (m_flag & ~clr);
    if (we) begin
      if (wa >= 7'h07 && wa <= 7'h0A) m_alm[wa - 7'h07] = wd;
      if (wa == 7'h0B) m_aie = wd[0];
    end
    @(posedge clk); #1;
    tick = 0; irq_clr = 0; host_wr = 0;
    e.tag = tag; e.rd = m_read(ra); e.fl = m_flag; e.irqn = !(m_flag && m_aie);
    q.push_back(e);
  endtask

  task automatic wr(input string tag, input logic [6:0] a, input logic [7:0] d);
    step(tag, 0, sec_in, min_in, hour_in, day_in, 0, 1, a, d, a);
  endtask
  task automatic rd(input string tag, input logic [6:0] a);
    step(tag, 0, sec_in, min_in, hour_in, day_in, 0, 0, 0, 0, a);
  endtask
  task automatic tk(input string tag, input logic [6:0] s, m, h, d);
    step(tag, 1, s, m, h, d, 0, 0, 0, 0, 7'h0C);
  endtask
  task automatic clr(input string tag);
    step(tag, 0, sec_in, min_in, hour_in, day_in, 1, 0, 0, 0, 7'h0C);
  endtask

  // monitor: pops one expected item per result cycle, mid-cycle
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_tests++;
      if (host_rdata !== e.rd || irq_flag !== e.fl || irq_n !== e.irqn) begin
        n_fail++;
        $display("FAIL %s: rdata=%h flag=%b irq_n=%b expected rdata=%h flag=%b irq_n=%b",
                 e.tag, host_rdata, irq_flag, irq_n, e.rd, e.fl, e.irqn);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    for (int a = 7; a <= 12; a++) rd("R1 reset", 7'(a));
    // R10 map and ignored addresses
    wr("R10 enable", 7'h0B, 8'hFF);
    wr("R10 unmapped write", 7'h05, 8'h5A);
    rd("R10 unmapped read", 7'h05);
    rd("R10 ctrl read", 7'h0B);
    wr("R10 sec alarm", 7'h07, 8'h30);
    wr("R10 min alarm", 7'h08, 8'h15);
    wr("R10 hour alarm", 7'h09, 8'h08);
    wr("R10 day alarm", 7'h0A, 8'h03);
    // R2 weekly
    tk("R2 day differs", 7'h30, 7'h15, 7'h08, 7'h04);
    tk("R2 sec differs", 7'h31, 7'h15, 7'h08, 7'h03);
    tk("R2 hour differs", 7'h30, 7'h15, 7'h18, 7'h03);
    tk("R2 full match", 7'h30, 7'h15, 7'h08, 7'h03);
    // R8 sticky across non-matching ticks, then clear
    tk("R8 sticky", 7'h31, 7'h15, 7'h08, 7'h03);
    clr("R8 clear");
    // R7 writes never set flag
    step("R7 time held", 0, 7'h44, 7'h22, 7'h11, 7'h05, 0, 0, 0, 0, 7'h0C);
    wr("R7 write sec", 7'h07, 8'h44);
    wr("R7 write min", 7'h08, 8'h22);
    wr("R7 write hour", 7'h09, 8'h11);
    wr("R7 write day", 7'h0A, 8'h05);
    rd("R7 no flag after writes", 7'h0C);
    // R3 daily
    wr("R3 mask day", 7'h0A, 8'h86);
    tk("R3 day ignored", 7'h44, 7'h22, 7'h11, 7'h01);
    clr("R3 clear");
    tk("R3 hour differs", 7'h44, 7'h22, 7'h12, 7'h06);
    // R4 hourly
    wr("R4 mask hour", 7'h09, 8'h91);
    tk("R4 min differs", 7'h44, 7'h23, 7'h11, 7'h06);
    tk("R4 hour ignored", 7'h44, 7'h22, 7'h05, 7'h02);
    clr("R4 clear");
    // R5 each minute
    wr("R5 mask min", 7'h08, 8'hA2);
    tk("R5 sec differs", 7'h45, 7'h22, 7'h11, 7'h05);
    tk("R5 sec match", 7'h44, 7'h59, 7'h23, 7'h07);
    clr("R5 clear");
    // R6 every second, value bits ignored
    wr("R6 mask sec", 7'h07, 8'hC4);
    tk("R6 any tick", 7'h01, 7'h02, 7'h03, 7'h04);
    clr("R6 clear");
    tk("R6 another tick", 7'h59, 7'h59, 7'h23, 7'h07);
    // R8 clear and hit in same cycle: flag stays
    step("R8 clear with hit", 1, 7'h10, 7'h10, 7'h10, 7'h01, 1, 0, 0, 0, 7'h0C);
    clr("R8 clear alone");
    // R9 enable gating
    wr("R9 disable", 7'h0B, 8'h00);
    tk("R9 flag without irq", 7'h02, 7'h00, 7'h00, 7'h01);
    wr("R9 enable with flag", 7'h0B, 8'h01);
    clr("R9 clear releases irq");
    // R10 full readback incl. mask bits
    rd("R10 sec readback", 7'h07);
    rd("R10 day readback", 7'h0A);
    rd("R10 status read-only", 7'h0C);
    wr("R10 status write ignored", 7'h0C, 8'hFF);
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule